// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the horizontal and vertical raster timing for a parallel RGB panel. Software writes five timing quantities per axis (a reference-to-sync offset, the sync pulse width, the back porch, the active size and the front porch), each as one 32-bit word that carries the vertical value in its upper half and the horizontal value in its lower half. From these the block drives horizontal sync, vertical sync, data enable, the x/y coordinate of the current active pixel, a one-pixel vertical-blank pulse and a one-pixel frame-end pulse. A control word sets the sync polarities, a data-enable suppress mode and a fractional pixel clock divider that turns the parent clock into a pixel clock enable.

Each axis is a state machine with the states PH_IDLE, PH_REF, PH_SYNC, PH_BACK, PH_ACT and PH_FRONT. From PH_IDLE it starts (when both active sizes in the working copy are nonzero) into the first segment of nonzero length. Within a segment the counter advances on every step; at the end of a segment the machine moves to the next segment of nonzero length, so segments of length zero are skipped. After the last segment it wraps back to the first nonzero segment, or to PH_IDLE when the newly loaded active size is zero. The horizontal machine steps on every pixel clock enable; the vertical machine steps when the horizontal one wraps.

Timing words pass through a working copy that is loaded only at the frame boundary (or at any pixel enable while idle), so a write during a frame never changes that frame. Polarity, the data-enable mode and the divider take effect at once.

Top module: `dtg_top`

## Requirements
- R1: After reset hsync, vsync, de, px_x, px_y, vblank and frame_end are all 0, and the block stays idle (sync outputs at their inactive level, coordinates 0, no pulses) while either axis has an active size of zero.
- R2: Register address 0 holds the reference-to-sync offset, 1 the sync width, 2 the back porch, 3 the active size and 4 the front porch, each with the vertical value in bits [31:16] and the horizontal value in bits [15:0]; address 5 is the control word (bit 0 inverts hsync, bit 1 inverts vsync, bit 2 suppresses data enable, bits [15:8] hold the divider D); writes to addresses 6 and 7 have no effect.
- R3: Each line consists of the reference offset, then the sync pulse (hsync active) for the sync width, then the back porch, the active region and the front porch, in pixels; the line length is their sum.
- R4: Each frame runs through the same five segments counted in lines, with vsync active during the vertical sync segment.
- R5: de is high exactly when both axes are in their active region; px_x and px_y count from 0 across the active region and are 0 elsewhere, so a frame holds active width times active height enabled pixels.
- R6: With a polarity bit set the matching sync output is inverted, becoming active low.
- R7: With the suppress bit set de stays low while all other timing continues.
- R8: With divider value D the pixel clock enable fires at 2/(D+2) of the parent clock rate, spread as evenly as the half steps allow; D = 0 gives an enable on every cycle.
- R9: vblank is high for exactly one pixel per frame, the first pixel after the last active line.
- R10: frame_end is high for exactly one pixel per frame, the last active pixel of the last active line.
- R11: Timing words written during a frame take effect at the start of the next frame; the frame in progress completes with the old values.
- R12: A segment of length zero is skipped; it produces no pixel and no line.
- R13: Writing an active size of zero while running lets the current frame finish and then returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable from the divider |
| hsync | output | 1 | Horizontal sync, polarity per control bit 0 |
| vsync | output | 1 | Vertical sync, polarity per control bit 1 |
| de | output | 1 | Data enable |
| px_x | output | 16 | Active pixel column, 0 outside the active region |
| px_y | output | 16 | Active line number, 0 outside the active region |
| vblank | output | 1 | One-pixel vertical-blank pulse |
| frame_end | output | 1 | One-pixel end-of-frame pulse |

## Verification
A reference model walks a line and frame position and is compared against every output on every cycle for several timing sets: one without a reference offset, one with nonzero offsets on both axes, and one with zero-length sync, porch and front segments, which separates the segment ordering, the zero-length skip and the wrap point from one another. The same frames are replayed with inverted polarities, with data enable suppressed and with a fractional divider, which tells the polarity and suppress paths apart from the counters and shows that the counters advance only on the enable. A rewrite of all timing words in mid-frame and a drop of the active size to zero show whether the working copy loads at the frame boundary and not earlier, and the divider is measured by counting enables for several D values.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    // Segment order within a line or frame; the state machine walks it in this order.
    localparam int NSEG      = 5;
    localparam int SEG_REF   = 0;
    localparam int SEG_SYNC  = 1;
    localparam int SEG_BACK  = 2;
    localparam int SEG_ACT   = 3;
    localparam int SEG_FRONT = 4;
    localparam int CTRL_ADDR = 5;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REF   = 3'd1,
        PH_SYNC  = 3'd2,
        PH_BACK  = 3'd3,
        PH_ACT   = 3'd4,
        PH_FRONT = 3'd5
    } phase_e;

    typedef struct packed {
        logic       found;
        logic [2:0] idx;
    } pick_t;
endpackage

// File: rtl/dtg_clkdiv.sv
module dtg_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          ce
);
    localparam int AW = DW + 1;

    logic [AW-1:0] acc;
    logic [AW-1:0] acc_n;

    // Half-step accumulator: add 2 per cycle, fire when the sum reaches D+2.
    always_comb begin
        ce    = (acc >= AW'(div));
        acc_n = ce ? (acc - AW'(div)) : (acc + AW'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_n;
    end

    // R8
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> ce);
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs import dtg_pkg::*; #(
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [2*CW-1:0]           wdata,
    input  logic                      load,
    output logic [NSEG-1:0][CW-1:0]   h_live,
    output logic [NSEG-1:0][CW-1:0]   v_live,
    output logic [NSEG-1:0][CW-1:0]   h_sh,
    output logic [NSEG-1:0][CW-1:0]   v_sh,
    output logic                      hpol,
    output logic                      vpol,
    output logic                      de_off,
    output logic [DW-1:0]             div
);
    // Timing words: vertical in the upper half, horizontal in the lower half.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_live <= '0;
            v_live <= '0;
        end else begin
            for (int i = 0; i < NSEG; i++) begin
                if (we && addr == AW'(i)) begin
                    h_live[i] <= wdata[CW-1:0];
                    v_live[i] <= wdata[2*CW-1:CW];
                end
            end
        end
    end

    // Working copy used by the counters; loaded only at a frame boundary or while idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sh <= '0;
            v_sh <= '0;
        end else if (load) begin
            h_sh <= h_live;
            v_sh <= v_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpol   <= 1'b0;
            vpol   <= 1'b0;
            de_off <= 1'b0;
            div    <= '0;
        end else if (we && addr == AW'(CTRL_ADDR)) begin
            hpol   <= wdata[0];
            vpol   <= wdata[1];
            de_off <= wdata[2];
            div    <= wdata[8 +: DW];
        end
    end
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis import dtg_pkg::*; #(
    parameter int CW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    start,
    input  logic                    run,
    input  logic                    take_new,
    input  logic                    nrun,
    input  logic [NSEG-1:0][CW-1:0] len,
    input  logic [NSEG-1:0][CW-1:0] nlen,
    output phase_e                  phase,
    output logic [CW-1:0]           cnt,
    output logic                    last
);
    // Lowest segment index at or above 'from' whose length is nonzero.
    function automatic pick_t first_nz(input logic [NSEG-1:0][CW-1:0] l, input int from);
        pick_t p;
        p = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (i >= from && l[i] != '0) begin
                p.found = 1'b1;
                p.idx   = 3'(i);
            end
        end
        return p;
    endfunction

    phase_e        phase_n;
    logic [CW-1:0] cnt_n;
    int            cur;
    logic          seg_end;
    pick_t         later;
    pick_t         wrap_pick;

    always_comb begin
        cur       = (phase == PH_IDLE) ? 0 : (int'(phase) - 1);
        seg_end   = (phase != PH_IDLE) && (cnt == len[cur] - CW'(1));
        later     = first_nz(len, cur + 1);
        last      = seg_end && !later.found;
        wrap_pick = '0;
        phase_n   = phase;
        cnt_n     = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (start && run) begin
                    wrap_pick = first_nz(len, 0);
                    phase_n   = phase_e'(wrap_pick.idx + 3'd1);
                    cnt_n     = '0;
                end
            end
            default: begin
                if (step) begin
                    if (!seg_end) begin
                        cnt_n = cnt + CW'(1);
                    end else if (later.found) begin
                        phase_n = phase_e'(later.idx + 3'd1);
                        cnt_n   = '0;
                    end else if (take_new && !nrun) begin
                        phase_n = PH_IDLE;
                        cnt_n   = '0;
                    end else begin
                        wrap_pick = first_nz(take_new ? nlen : len, 0);
                        phase_n   = phase_e'(wrap_pick.idx + 3'd1);
                        cnt_n     = '0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_n;
            cnt   <= cnt_n;
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !step) |=> ($stable(cnt) && $stable(phase)));

    // R12
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (cnt < len[cur]));
endmodule

// File: rtl/dtg_top.sv
module dtg_top import dtg_pkg::*; #(
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [2*CW-1:0] cfg_wdata,
    output logic            pix_ce,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [CW-1:0]   px_x,
    output logic [CW-1:0]   px_y,
    output logic            vblank,
    output logic            frame_end
);
    logic [NSEG-1:0][CW-1:0] h_live, v_live, h_sh, v_sh;
    logic                    hpol, vpol, de_off;
    logic [DW-1:0]           div;
    logic                    run, nrun, load;
    logic                    h_last, v_last, h_wrap, v_leave_act;
    phase_e                  h_phase, v_phase;
    logic [CW-1:0]           h_cnt, v_cnt;
    logic                    vblank_q;

    assign run    = (h_sh[SEG_ACT] != '0) && (v_sh[SEG_ACT] != '0);
    assign nrun   = (h_live[SEG_ACT] != '0) && (v_live[SEG_ACT] != '0);
    assign h_wrap = pix_ce && h_last;
    assign load   = (pix_ce && !run) || (h_wrap && v_last);

    dtg_clkdiv #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .div(div), .ce(pix_ce)
    );

    dtg_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .load(load), .h_live(h_live), .v_live(v_live), .h_sh(h_sh), .v_sh(v_sh),
        .hpol(hpol), .vpol(vpol), .de_off(de_off), .div(div)
    );

    dtg_axis #(.CW(CW)) u_hax (
        .clk(clk), .rst_n(rst_n), .step(pix_ce), .start(pix_ce), .run(run),
        .take_new(v_last), .nrun(nrun), .len(h_sh), .nlen(h_live),
        .phase(h_phase), .cnt(h_cnt), .last(h_last)
    );

    dtg_axis #(.CW(CW)) u_vax (
        .clk(clk), .rst_n(rst_n), .step(h_wrap), .start(pix_ce), .run(run),
        .take_new(1'b1), .nrun(nrun), .len(v_sh), .nlen(v_live),
        .phase(v_phase), .cnt(v_cnt), .last(v_last)
    );

    assign v_leave_act = h_wrap && (v_phase == PH_ACT) && (v_cnt == v_sh[SEG_ACT] - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vblank_q <= 1'b0;
        else if (pix_ce) vblank_q <= v_leave_act;
    end

    // Output decode from the two axis states.
    always_comb begin
        hsync     = (h_phase == PH_SYNC) ^ hpol;
        vsync     = (v_phase == PH_SYNC) ^ vpol;
        de        = !de_off && (h_phase == PH_ACT) && (v_phase == PH_ACT);
        px_x      = (h_phase == PH_ACT) ? h_cnt : '0;
        px_y      = (v_phase == PH_ACT) ? v_cnt : '0;
        vblank    = vblank_q;
        frame_end = (h_phase == PH_ACT) && (h_cnt == h_sh[SEG_ACT] - CW'(1)) &&
                    (v_phase == PH_ACT) && (v_cnt == v_sh[SEG_ACT] - CW'(1));
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (px_x == '0 && px_y == '0 && !de && !frame_end));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pix_ce) |=> ($stable(h_sh) && $stable(v_sh)));

    // R9
    vblank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> ($past(v_phase) == PH_ACT));
endmodule

// File: tb/tb_dtg_top.sv
module tb_dtg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_ce, hsync, vsync, de, vblank, frame_end;
    logic [15:0] px_x, px_y;

    dtg_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .de(de), .px_x(px_x), .px_y(px_y), .vblank(vblank), .frame_end(frame_end)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int errors  = 0;

    // Timing sets, segment order: ref, sync, back, active, front.
    int A_h[5] = '{0, 2, 3, 5, 2};
    int A_v[5] = '{0, 1, 2, 3, 1};
    int B_h[5] = '{1, 1, 2, 4, 3};
    int B_v[5] = '{1, 2, 1, 2, 2};
    int C_h[5] = '{0, 0, 0, 3, 1};
    int C_v[5] = '{0, 2, 0, 2, 0};
    int Z_v[5] = '{0, 0, 0, 0, 0};

    int  ch[5], cv[5], ph[5], pv[5];
    bit  pend = 0;
    bit  hpol = 0, vpol = 0, deoff = 0;
    int  line = 0, pix = 0;
    bit  prev_ce = 0;
    int  de_cnt = 0, fe_cnt = 0, vb_cnt = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic prog(input int h[5], input int v[5]);
        for (int i = 0; i < 5; i++) wr(i, {v[i][15:0], h[i][15:0]});
    endtask

    function automatic int tot(input int L[5]);
        return L[0] + L[1] + L[2] + L[3] + L[4];
    endfunction

    function automatic void seg_of(input int p, input int L[5], output int s, output int off);
        int acc;
        acc = 0; s = -1; off = 0;
        for (int i = 0; i < 5; i++) begin
            if (p >= acc && p < acc + L[i]) begin s = i; off = p - acc; end
            acc += L[i];
        end
    endfunction

    function automatic bit running();
        return (ch[3] != 0) && (cv[3] != 0);
    endfunction

    task automatic advance();
        pix++;
        if (pix >= tot(ch)) begin
            pix = 0;
            line++;
            if (line >= tot(cv)) begin
                line = 0;
                if (pend) begin ch = ph; cv = pv; pend = 0; end
            end
        end
    endtask

    // Cycle-by-cycle comparison against the position model.
    task automatic cmp(input int n, input string tag);
        int hs, ho, vs, vo, ehs, evs, ede, ex, ey, efe, evb;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (prev_ce && running()) advance();
            prev_ce = pix_ce;
            if (running()) begin
                seg_of(pix, ch, hs, ho);
                seg_of(line, cv, vs, vo);
                ehs = int'((hs == 1) ^ hpol);
                evs = int'((vs == 1) ^ vpol);
                ede = int'(!deoff && hs == 3 && vs == 3);
                ex  = (hs == 3) ? ho : 0;
                ey  = (vs == 3) ? vo : 0;
                efe = int'(hs == 3 && ho == ch[3] - 1 && vs == 3 && vo == cv[3] - 1);
                evb = int'(pix == 0 && line == (cv[0] + cv[1] + cv[2] + cv[3]) % tot(cv));
            end else begin
                ehs = int'(hpol); evs = int'(vpol);
                ede = 0; ex = 0; ey = 0; efe = 0; evb = 0;
            end
            check(tag, "hsync", int'(hsync), ehs);
            check(tag, "vsync", int'(vsync), evs);
            check(tag, "de", int'(de), ede);
            check(tag, "px_x", int'(px_x), ex);
            check(tag, "px_y", int'(px_y), ey);
            check(tag, "frame_end", int'(frame_end), efe);
            check(tag, "vblank", int'(vblank), evb);
            if (prev_ce) begin
                de_cnt += int'(de);
                fe_cnt += int'(frame_end);
                vb_cnt += int'(vblank);
            end
        end
    endtask

    task automatic align(input string tag);
        int k;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!frame_end && k < 3000);
        check(tag, "frame_end found", int'(frame_end), 1);
        line    = cv[0] + cv[1] + cv[2] + cv[3] - 1;
        pix     = ch[0] + ch[1] + ch[2] + ch[3] - 1;
        prev_ce = pix_ce;
    endtask

    task automatic settle();
        repeat (400) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "hsync after reset", int'(hsync), 0);
        check("R1", "vsync after reset", int'(vsync), 0);
        check("R1", "de after reset", int'(de), 0);
        check("R1", "px_x after reset", int'(px_x), 0);
        check("R1", "px_y after reset", int'(px_y), 0);
        check("R1", "vblank after reset", int'(vblank), 0);
        check("R1", "frame_end after reset", int'(frame_end), 0);
    endtask

    task automatic t_idle_partial();
        // R1: horizontal set only, vertical active zero -> stays idle
        prog(A_h, Z_v);
        ch = A_h; cv = Z_v; pend = 0;
        cmp(60, "R1");
    endtask

    task automatic t_frame_basic();
        prog(A_h, A_v);
        ch = A_h; cv = A_v;
        settle();
        align("R3");
        de_cnt = 0; fe_cnt = 0; vb_cnt = 0;
        cmp(tot(A_h) * tot(A_v), "R3 R4 R5 R9 R10");
        check("R5", "enabled pixels per frame", de_cnt, A_h[3] * A_v[3]);
        check("R10", "frame_end per frame", fe_cnt, 1);
        check("R9", "vblank per frame", vb_cnt, 1);
    endtask

    task automatic t_ignored();
        align("R2");
        fork
            cmp(2 * tot(A_h) * tot(A_v), "R2");
            begin
                repeat (10) @(negedge clk);
                wr(6, 32'h0001_0001);
                wr(7, 32'hFFFF_FFFF);
            end
        join
    endtask

    task automatic t_polarity();
        wr(5, 32'h0000_0003);
        hpol = 1; vpol = 1;
        align("R6");
        cmp(tot(A_h) * tot(A_v), "R6");
        wr(5, 32'h0000_0000);
        hpol = 0; vpol = 0;
    endtask

    task automatic t_de_off();
        wr(5, 32'h0000_0004);
        deoff = 1;
        align("R7");
        de_cnt = 0;
        cmp(tot(A_h) * tot(A_v), "R7");
        check("R7", "enabled pixels while suppressed", de_cnt, 0);
        wr(5, 32'h0000_0000);
        deoff = 0;
    endtask

    task automatic t_div_frame();
        wr(5, 32'h0000_0100);
        align("R8");
        cmp(2 * tot(A_h) * tot(A_v), "R8");
        wr(5, 32'h0000_0000);
    endtask

    task automatic t_div_rate();
        int dv[4] = '{0, 1, 2, 4};
        int n;
        for (int j = 0; j < 4; j++) begin
            wr(5, {16'h0, 8'(dv[j]), 8'h00});
            repeat (20) @(negedge clk);
            n = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                n += int'(pix_ce);
            end
            check("R8", $sformatf("enables in 60 cycles D=%0d", dv[j]), n, 120 / (dv[j] + 2));
        end
        wr(5, 32'h0000_0000);
        settle();
    endtask

    task automatic t_switch();
        align("R11");
        fork
            cmp(tot(A_h) * tot(A_v) + 2 * tot(B_h) * tot(B_v) + 20, "R11");
            begin
                repeat (30) @(negedge clk);
                prog(B_h, B_v);
                ph = B_h; pv = B_v; pend = 1;
            end
        join
    endtask

    task automatic t_to_idle();
        align("R13");
        fork
            cmp(2 * tot(B_h) * tot(B_v) + 30, "R13");
            begin
                repeat (20) @(negedge clk);
                wr(3, {16'd0, 16'(B_h[3])});
                ph = B_h; pv = B_v; pv[3] = 0; pend = 1;
            end
        join
        check("R13", "idle after zero active", int'(running()), 0);
    endtask

    task automatic t_zero_seg();
        prog(C_h, C_v);
        ch = C_h; cv = C_v; pend = 0;
        settle();
        align("R12");
        vb_cnt = 0; fe_cnt = 0;
        cmp(3 * tot(C_h) * tot(C_v), "R12");
        check("R12", "vblank over three frames", vb_cnt, 3);
        check("R12", "frame_end over three frames", fe_cnt, 3);
    endtask

    initial begin
        ch = Z_v; cv = Z_v; ph = Z_v; pv = Z_v;
        t_reset();
        t_idle_partial();
        t_frame_basic();
        t_ignored();
        t_polarity();
        t_de_off();
        t_div_frame();
        t_div_rate();
        t_switch();
        t_to_idle();
        t_zero_seg();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule